// File: doc/BRIEF.md
# Synchronous Trigger Port with Serial Trigger Number

This block drives one device-under-test port in the synchronous handshake style. It runs in the interface clock domain, which is 40 MHz by default. Upstream trigger logic presents a trigger request each cycle. When the request is accepted, the block raises a trigger line toward the device for one clock. The device can hold BUSY high to refuse triggers. The block combines BUSY with its own reasons to refuse into a single veto output, and it drops any request that meets a high veto.

The sync/T0 line carries two kinds of traffic:

- **Timestamp reset.** A start-of-run command makes the block emit a single-cycle pulse on sync/T0 so that the device can zero its timestamps. The same pulse clears the trigger counter.
- **Trigger number.** In trigger-number mode, each accepted trigger is followed directly by its trigger number, sent one bit per clock with the least significant bit first. The trigger number is the count of triggers accepted since the last timestamp-reset pulse.

The block arbitrates between these two uses of the line. New triggers are held off while a number is being sent. A run start that arrives during a transfer is deferred until the transfer has finished.

Top module: `sync_trig_if`

## Requirements
- R1: After reset, `dut_trig` and `dut_t0` are low, `veto` follows `busy_i` alone, and the trigger counter is zero.
- R2: A trigger request seen in cycle N with `veto` low is accepted: `dut_trig` is high in cycle N+1 only. Accepted requests in consecutive cycles give consecutive pulses.
- R3: `veto` is high whenever `busy_i` is high, whenever `run_start` is high, while a run start is pending, and while a number transfer is active. A request made while `veto` is high produces no `dut_trig` pulse and does not advance the counter.
- R4: A `run_start` in cycle N with no number transfer active drives `dut_t0` high in cycle N+1, for that cycle only.
- R5: The trigger number is the count of triggers accepted since the last sync/T0 timestamp pulse, modulo 2^NUM_W. The first trigger after a run start therefore carries number 0.
- R6: When `num_mode` is high at acceptance in cycle N, `dut_t0` carries bit k of the trigger number (k = 0 first) in cycle N+2+k, for k = 0 to NUM_W-1.
- R7: After a trigger accepted in number mode in cycle N, `veto` is high in cycles N+1 through N+NUM_W. Requests in those cycles are ignored.
- R8: A `run_start` that arrives during a transfer is held. Its single-cycle `dut_t0` pulse appears in the cycle right after the last number bit.
- R9: When `num_mode` is low at acceptance, `dut_t0` stays low after the trigger pulse, and the next request is accepted in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_start | input | 1 | Start-of-run command, one cycle |
| trig_req | input | 1 | Trigger request from the trigger logic |
| num_mode | input | 1 | 1 = send the trigger number after each trigger |
| busy_i | input | 1 | BUSY from the device, 1 = refuse triggers |
| veto | output | 1 | Combined refusal back to the trigger logic, combinational |
| dut_trig | output | 1 | Trigger line to the device |
| dut_t0 | output | 1 | Sync/T0 line to the device |

## Verification
Each result has a fixed cycle at which it is due:

- `veto` is combinational, so it is compared in the same cycle as the inputs that drive it.
- `dut_trig` and a timestamp pulse each pass through one register, so they are compared one clock after their cause.
- Number bits begin two clocks after acceptance and continue for NUM_W cycles.

The bench applies inputs just after a falling edge and checks `veto` shortly afterwards. It then advances its reference model at the rising edge and compares both lines at the next falling edge, which is exactly one register stage later. Serialised words are also rebuilt from the observed bits and compared with the expected count as a whole.

// File: rtl/sti_pkg.sv
package sti_pkg;
  // Pair of lines driven toward the device.
  typedef struct packed {
    logic trig;
    logic t0;
  } sti_line_t;

  localparam sti_line_t STI_LINE_IDLE = '{trig: 1'b0, t0: 1'b0};
endpackage

// File: rtl/sti_rst_sync.sv
module sti_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sti_veto_arb.sv
module sti_veto_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic trig_req,
  input  logic busy_i,
  input  logic ser_active,
  output logic accept,
  output logic t0_fire,
  output logic veto
);
  logic pend_q, pend_d;
  logic t0_want;

  // A run start is wanted on the command itself or while it is held.
  assign t0_want = run_start | pend_q;
  assign t0_fire = t0_want & ~ser_active;
  assign veto    = busy_i | ser_active | t0_want;
  assign accept  = trig_req & ~veto;

  always_comb begin
    pend_d = pend_q;
    if (t0_fire)      pend_d = 1'b0;
    else if (t0_want) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/sti_trig_counter.sv
module sti_trig_counter #(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             incr,
  output logic [NUM_W-1:0] count
);
  logic [NUM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clear | incr;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (incr) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/sti_num_shifter.sv
module sti_num_shifter #(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] load_val,
  output logic             ser_active,
  output logic             ser_bit
);
  localparam int LEFT_W = $clog2(NUM_W + 1);
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(NUM_W);

  logic [NUM_W-1:0]  sr_q, sr_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              sr_en;

  // Loading and shifting never coincide: a load needs the veto low.
  assign ser_active = (left_q != '0);
  assign ser_bit    = sr_q[0];
  assign sr_en      = load | ser_active;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (load) begin
      sr_d   = load_val;
      left_d = LEFT_FULL;
    end else if (ser_active) begin
      sr_d   = sr_q >> 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (sr_en) begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/sync_trig_if.sv
module sync_trig_if #(
  parameter int NUM_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic trig_req,
  input  logic num_mode,
  input  logic busy_i,
  output logic veto,
  output logic dut_trig,
  output logic dut_t0
);
  import sti_pkg::*;

  logic             rst_sync_n;
  logic             accept;
  logic             t0_fire;
  logic             ser_active;
  logic             ser_bit;
  logic [NUM_W-1:0] count;
  sti_line_t        line_q, line_d;

  sti_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sti_veto_arb i_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run_start  (run_start),
    .trig_req   (trig_req),
    .busy_i     (busy_i),
    .ser_active (ser_active),
    .accept     (accept),
    .t0_fire    (t0_fire),
    .veto       (veto)
  );

  sti_trig_counter #(.NUM_W(NUM_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (t0_fire),
    .incr  (accept),
    .count (count)
  );

  sti_num_shifter #(.NUM_W(NUM_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept & num_mode),
    .load_val   (count),
    .ser_active (ser_active),
    .ser_bit    (ser_bit)
  );

  // The timestamp pulse wins the sync/T0 line only when no bit is due.
  always_comb begin
    line_d.trig = accept;
    if (t0_fire)         line_d.t0 = 1'b1;
    else if (ser_active) line_d.t0 = ser_bit;
    else                 line_d.t0 = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) line_q <= STI_LINE_IDLE;
    else             line_q <= line_d;
  end

  assign dut_trig = line_q.trig;
  assign dut_t0   = line_q.t0;
endmodule

// File: rtl/sti_checker.sv
module sti_checker (
  input logic clk,
  input logic rst_n,
  input logic run_start,
  input logic trig_req,
  input logic num_mode,
  input logic busy_i,
  input logic veto,
  input logic dut_trig,
  input logic dut_t0,
  input logic ser_active
);
  // R2: an accepted request produces the trigger pulse one clock later.
  p_accept_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !veto) |=> dut_trig);

  // R3: a refused or absent request leaves the trigger line low.
  p_refused_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_req || veto) |=> !dut_trig);

  // R3: BUSY and a run start always appear on the veto.
  p_busy_veto_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i || run_start) |-> veto);

  // R4: a run start with the line free gives the T0 pulse one clock later.
  p_t0_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !ser_active) |=> dut_t0);

  // R7: a trigger in number mode starts a transfer that holds the veto.
  p_ser_veto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !veto && num_mode) |=> (veto && ser_active));

  // R9: a trigger in plain mode leaves sync/T0 low in its pulse cycle.
  p_plain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !veto && !num_mode) |=> !dut_t0);
endmodule

bind sync_trig_if sti_checker i_sti_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run_start  (run_start),
  .trig_req   (trig_req),
  .num_mode   (num_mode),
  .busy_i     (busy_i),
  .veto       (veto),
  .dut_trig   (dut_trig),
  .dut_t0     (dut_t0),
  .ser_active (ser_active)
);

// File: tb/test_sync_trig_if.sv
module test_sync_trig_if;
  localparam int CLK_PERIOD = 25;
  localparam int W = 8;

  logic clk;
  logic rst_n;
  logic run_start, trig_req, num_mode, busy_i;
  logic veto, dut_trig, dut_t0;

  int n_chk;
  int n_fail;

  // Reference model state, kept from the requirements.
  logic [W-1:0] m_cnt;
  logic [W-1:0] m_sr;
  int           m_left;
  logic         m_pend;
  logic         m_trig;
  logic         m_t0;
  logic         obs_t0;

  sync_trig_if #(.NUM_W(W)) i_sync_trig_if (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .trig_req  (trig_req),
    .num_mode  (num_mode),
    .busy_i    (busy_i),
    .veto      (veto),
    .dut_trig  (dut_trig),
    .dut_t0    (dut_t0)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_word(input logic [W-1:0] act, input logic [W-1:0] exp,
                            input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // One clock: drive just after a falling edge, check at the next one.
  task automatic step(input logic i_rs, input logic i_tr, input logic i_bz,
                      input logic i_md);
    logic  want, ser, fire, acc;
    string t0_tag;
    run_start = i_rs;
    trig_req  = i_tr;
    busy_i    = i_bz;
    num_mode  = i_md;
    #1;
    want = i_rs | m_pend;
    ser  = (m_left != 0);
    fire = want & ~ser;
    acc  = i_tr & ~(i_bz | ser | want);
    check(veto, i_bz | ser | want, ser ? "R7" : "R3");
    if (fire)     t0_tag = m_pend ? "R8" : "R4";
    else if (ser) t0_tag = "R6";
    else          t0_tag = "R9";
    m_trig = acc;
    m_t0   = fire ? 1'b1 : (ser ? m_sr[0] : 1'b0);
    m_pend = want & ser;
    if (acc && i_md) begin
      m_sr   = m_cnt;
      m_left = W;
    end else if (ser) begin
      m_sr   = m_sr >> 1;
      m_left = m_left - 1;
    end
    if (fire)     m_cnt = '0;
    else if (acc) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    check(dut_trig, m_trig, m_trig ? "R2" : "R3");
    check(dut_t0, m_t0, t0_tag);
    obs_t0 = dut_t0;
  endtask

  // Trigger in number mode, then rebuild the word from the line (R5, R6).
  task automatic trig_and_read(input logic [W-1:0] exp_num, input logic busy_try);
    logic [W-1:0] word;
    step(1'b0, 1'b1, 1'b0, 1'b1);
    check(dut_trig, 1'b1, "R2");
    for (int k = 0; k < W; k++) begin
      step(1'b0, busy_try, 1'b0, 1'b1);
      word[k] = obs_t0;
    end
    check_word(word, exp_num, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    m_cnt  = '0;
    m_sr   = '0;
    m_left = 0;
    m_pend = 1'b0;
    m_trig = 1'b0;
    m_t0   = 1'b0;
    obs_t0 = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    run_start = 1'b0;
    trig_req  = 1'b0;
    num_mode  = 1'b0;
    busy_i    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state.
    check(dut_trig, 1'b0, "R1");
    check(dut_t0, 1'b0, "R1");
    check(veto, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dut_t0, 1'b0, "R1");
    // R1, R5: with no run start yet, the first number is zero.
    trig_and_read(8'd0, 1'b0);

    // R4: run start on an idle line.
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check(dut_t0, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(dut_t0, 1'b0, "R4");

    // R2, R9: back-to-back plain triggers.
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check(dut_trig, 1'b1, "R2");
    end
    // R3: BUSY drops the request.
    step(1'b0, 1'b1, 1'b1, 1'b0);
    check(dut_trig, 1'b0, "R3");
    // R5, R6, R7: the fourth trigger carries number 3; requests during the transfer are ignored.
    trig_and_read(8'd3, 1'b1);
    // R5: an ignored request did not advance the count.
    trig_and_read(8'd4, 1'b0);

    // R8: a run start in the middle of a transfer is deferred.
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < W - 1; k++) step(1'b0, 1'b0, 1'b0, 1'b1);
    check(dut_t0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check(dut_t0, 1'b0, "R8");

    // R3: run start and request in one cycle; the request is refused.
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check(dut_trig, 1'b0, "R3");
    check(dut_t0, 1'b1, "R4");
    // R5: number restarts at zero after the pulse.
    trig_and_read(8'd0, 1'b0);
    trig_and_read(8'd1, 1'b0);

    // Random mix over all requirements.
    for (int i = 0; i < 6000; i++) begin
      logic rs, tr, bz, md;
      rs = ($urandom % 40) == 0;
      tr = ($urandom % 10) < 4;
      bz = ($urandom % 10) < 2;
      md = ($urandom % 8) < 3;
      step(rs, tr, bz, md);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule